// File: doc/BRIEF.md
# Low-Power Wake and Mode Controller

This block decides the power mode and the host-link selection of a contactless transceiver. Two interface-select inputs and two boot straps are captured once, on the first clock edge after reset is released. After a configurable boot delay the controller either parks in one of two test modes or enters a low-battery state. In that state it reports card emulation while a reader field is present and power-down otherwise, and it never enables the host interrupt.

The controller leaves the low-battery state only on the wake event of the strapped host link, and only while pad power is good. There are three wake events. On SPI, chip select must stay low for a set number of cycles. On I2C, a matching address byte is followed by a clock-hold window of the same length. On the UART, a fixed eight-byte preamble must arrive. Once awake, the controller decodes framed configuration commands. One command selects normal operation. Another selects virtual-card operation and sets whether the interrupt is enabled. The wake window and the boot delay are parameters (`WAKE_CYC`, `BOOT_CYC`, with `BOOT_CYC` at least 2), so simulation can use short values.

States: `ST_BOOT`, `ST_LB_OFF`, `ST_LB_CARD`, `ST_AWAKE`, `ST_NORMAL`, `ST_VCARD`, `ST_TEST_EMU`, `ST_TEST_RF`.

Transitions:
- `ST_BOOT` moves to a test state or to a low-battery state when the boot count expires. The strap value picks which.
- `ST_LB_OFF` and `ST_LB_CARD` switch between each other as `field_on` changes.
- Both low-battery states go to `ST_AWAKE` on a completed wake event.
- `ST_AWAKE`, `ST_NORMAL` and `ST_VCARD` go to `ST_NORMAL` or `ST_VCARD` on an accepted command.
- The two test states are never left.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: `host_if_o` is taken from `{if_strap0, if_strap1}` on the first rising edge after reset release. The code is 00 -> 0 (UART), 10 -> 1 (I2C), 01 -> 2 (SPI) and 11 -> 3 (none). The output then holds that value until the next reset.
- R2: For the first `BOOT_CYC` rising edges after reset release, `mode_o` is 0 (boot) and `irq_en_o` is 0.
- R3: Boot straps `{mode_strap_hi, mode_strap_lo}` set the mode at the end of boot. A value of 11 or 10 leads to low battery. A value of 01 leads to `mode_o`=6 (emulation test) and 00 to `mode_o`=7 (RF test). Test modes are permanent, and wake events and commands have no effect on them.
- R4: In low battery, `mode_o` is 2 (card emulation) in the cycle after `field_on` is sampled high and 1 (power-down) after it is sampled low. `irq_en_o` is 0 throughout.
- R5: With SPI selected, `spi_cs_n` sampled low together with `pad_pwr_ok` high on `WAKE_CYC` consecutive edges moves `mode_o` to 3 (awake). Any shorter run, or a run without pad power, leaves low battery unchanged.
- R6: With I2C selected, an `i2c_addr_byte` of 0x48 accepted with pad power starts a hold. The block is awake after `WAKE_CYC` further edges with pad power. Other addresses have no effect, and a loss of pad power cancels the hold.
- R7: With UART selected, received bytes 55 55 00 00 00 00 00 FF (with pad power) wake the block on the FF byte. A mismatch restarts the search, keeping any trailing 55 bytes as a prefix.
- R8: Wake events of a host link that is not selected have no effect, and code 3 has no wake event at all.
- R9: Once awake, a command frame ends with `cmd_last`. Frame 14 01 gives `mode_o`=4 with `irq_en_o`=1. Frames 14 02 00 and 14 02 00 01 give `mode_o`=5 with `irq_en_o`=1, and frame 14 02 00 00 gives `mode_o`=5 with `irq_en_o`=0.
- R10: Any other frame is ignored and keeps mode and interrupt enable. This includes an unknown mode byte, a bad length and a bad fill byte. Frames ending before the block is awake are ignored as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_strap0 | input | 1 | Host-link select, first bit |
| if_strap1 | input | 1 | Host-link select, second bit |
| mode_strap_hi | input | 1 | Boot strap, upper bit |
| mode_strap_lo | input | 1 | Boot strap, lower bit |
| pad_pwr_ok | input | 1 | Pad supply present |
| field_on | input | 1 | External reader field detected |
| spi_cs_n | input | 1 | SPI chip select, active low |
| i2c_addr_vld | input | 1 | Strobe for a received I2C address byte |
| i2c_addr_byte | input | 8 | Received I2C address byte |
| uart_rx_vld | input | 1 | Strobe for a received UART byte |
| uart_rx_byte | input | 8 | Received UART byte |
| cmd_vld | input | 1 | Strobe for a decoded command byte |
| cmd_byte | input | 8 | Command byte |
| cmd_last | input | 1 | Marks the final byte of a command frame |
| mode_o | output | 3 | Current mode code |
| host_if_o | output | 2 | Latched host-link code |
| irq_en_o | output | 1 | Host interrupt enable |

## Verification
The two functions that can meet in one edge are the completion of a wake event and the low-battery field tracking, and a command frame can end on that same edge. The bench holds chip select low for one cycle less than the window. It then raises `field_on` and places the last byte of a 14 01 frame on the wake edge. The expected result is awake (3) with the interrupt off: wake takes priority over field tracking, and a frame that ends before the block is awake is ignored.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    typedef enum logic [1:0] {
        HIF_UART = 2'd0,
        HIF_I2C  = 2'd1,
        HIF_SPI  = 2'd2,
        HIF_NONE = 2'd3
    } hif_e;

    typedef enum logic [2:0] {
        MD_BOOT     = 3'd0,
        MD_PDOWN    = 3'd1,
        MD_LBCARD   = 3'd2,
        MD_AWAKE    = 3'd3,
        MD_NORMAL   = 3'd4,
        MD_VCARD    = 3'd5,
        MD_TEST_EMU = 3'd6,
        MD_TEST_RF  = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_LB_OFF,
        ST_LB_CARD,
        ST_AWAKE,
        ST_NORMAL,
        ST_VCARD,
        ST_TEST_EMU,
        ST_TEST_RF
    } state_e;

    localparam int         PRE_LEN       = 8;
    localparam logic [7:0] PRE_SYNC      = 8'h55;
    localparam logic [7:0] PRE_END       = 8'hFF;
    localparam logic [7:0] I2C_WAKE_ADDR = 8'h48;
    localparam logic [7:0] CFG_OPCODE    = 8'h14;
    localparam logic [7:0] CFG_NORMAL    = 8'h01;
    localparam logic [7:0] CFG_VCARD     = 8'h02;

    // Expected UART wake byte at a given position of the preamble.
    function automatic logic [7:0] preamble_byte(input int idx);
        if (idx < 2)
            return PRE_SYNC;
        else if (idx == PRE_LEN - 1)
            return PRE_END;
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
    import pwr_wake_pkg::*;
#(
    parameter int WAKE_CYC = 13560
)
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  hif_e       hif,
    input  logic       pad_pwr_ok,
    input  logic       spi_cs_n,
    input  logic       i2c_addr_vld,
    input  logic [7:0] i2c_addr_byte,
    input  logic       uart_rx_vld,
    input  logic [7:0] uart_rx_byte,
    output logic       wake_o
);

    localparam int               CNT_W    = $clog2(WAKE_CYC + 1);
    localparam int               IDX_W    = $clog2(PRE_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PRE_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_TWO  = IDX_W'(2);

    logic [CNT_W-1:0] hold_cnt_q;
    logic             stretch_q;
    logic [IDX_W-1:0] pre_idx_q, pre_idx_d;
    logic             sel_spi, sel_i2c, sel_uart;
    logic             hold_cond, hold_done, addr_hit, rx_take, rx_match;

    assign sel_spi   = arm && (hif == HIF_SPI);
    assign sel_i2c   = arm && (hif == HIF_I2C);
    assign sel_uart  = arm && (hif == HIF_UART);

    assign hold_cond = pad_pwr_ok && ((sel_spi && !spi_cs_n) || (sel_i2c && stretch_q));
    assign hold_done = hold_cond && (hold_cnt_q == CNT_LAST);
    assign addr_hit  = sel_i2c && pad_pwr_ok && !stretch_q && i2c_addr_vld
                       && (i2c_addr_byte == I2C_WAKE_ADDR);
    assign rx_take   = sel_uart && pad_pwr_ok && uart_rx_vld;
    assign rx_match  = (uart_rx_byte == preamble_byte(int'(pre_idx_q)));

    // Preamble search with overlap: trailing sync bytes stay a valid prefix.
    always_comb begin
        pre_idx_d = pre_idx_q;
        if (!sel_uart || !pad_pwr_ok) begin
            pre_idx_d = '0;
        end else if (uart_rx_vld) begin
            if (rx_match)
                pre_idx_d = (pre_idx_q == IDX_LAST) ? '0 : pre_idx_q + 1'b1;
            else if (uart_rx_byte == PRE_SYNC)
                pre_idx_d = (pre_idx_q == IDX_TWO) ? IDX_TWO : IDX_W'(1);
            else
                pre_idx_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt_q <= '0;
            stretch_q  <= 1'b0;
            pre_idx_q  <= '0;
        end else begin
            pre_idx_q <= pre_idx_d;
            if (!hold_cond || hold_done)
                hold_cnt_q <= '0;
            else
                hold_cnt_q <= hold_cnt_q + 1'b1;
            if (!sel_i2c || !pad_pwr_ok || hold_done)
                stretch_q <= 1'b0;
            else if (addr_hit)
                stretch_q <= 1'b1;
        end
    end

    assign wake_o = hold_done || (rx_take && rx_match && (pre_idx_q == IDX_LAST));

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt_q <= CNT_LAST);
    p_cs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_spi && spi_cs_n) |=> (hold_cnt_q == '0));
    p_wake_pwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> pad_pwr_ok);

endmodule

// File: rtl/pwr_cfg_decode.sv
module pwr_cfg_decode
    import pwr_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cmd_vld,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_last,
    output logic       go_normal,
    output logic       go_vcard,
    output logic       vcard_irq
);

    logic [2:0] pos_q;
    logic       ok_q, sel_vc_q;
    logic       take, fits, byte_fits;

    assign take = en && cmd_vld;

    always_comb begin
        unique case (pos_q)
            3'd0:    byte_fits = (cmd_byte == CFG_OPCODE);
            3'd1:    byte_fits = (cmd_byte == CFG_NORMAL) || (cmd_byte == CFG_VCARD);
            3'd2:    byte_fits = sel_vc_q && (cmd_byte == 8'h00);
            3'd3:    byte_fits = sel_vc_q && ((cmd_byte == 8'h00) || (cmd_byte == 8'h01));
            default: byte_fits = 1'b0;
        endcase
    end

    assign fits      = ok_q && byte_fits;
    assign go_normal = take && cmd_last && fits && (pos_q == 3'd1) && (cmd_byte == CFG_NORMAL);
    assign go_vcard  = take && cmd_last && fits && ((pos_q == 3'd2) || (pos_q == 3'd3));
    assign vcard_irq = (pos_q == 3'd2) || (cmd_byte == 8'h01);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q    <= '0;
            ok_q     <= 1'b1;
            sel_vc_q <= 1'b0;
        end else if (!en || (take && cmd_last)) begin
            pos_q    <= '0;
            ok_q     <= 1'b1;
            sel_vc_q <= 1'b0;
        end else if (take) begin
            if (pos_q != 3'd7)
                pos_q <= pos_q + 1'b1;
            ok_q <= fits;
            if (pos_q == 3'd1)
                sel_vc_q <= (cmd_byte == CFG_VCARD);
        end
    end

    p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_normal, go_vcard}));
    p_frame_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_last) |=> (pos_q == 3'd0));

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int WAKE_CYC = 13560,
    parameter int BOOT_CYC = 27120
)
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       if_strap0,
    input  logic       if_strap1,
    input  logic       mode_strap_hi,
    input  logic       mode_strap_lo,
    input  logic       pad_pwr_ok,
    input  logic       field_on,
    input  logic       spi_cs_n,
    input  logic       i2c_addr_vld,
    input  logic [7:0] i2c_addr_byte,
    input  logic       uart_rx_vld,
    input  logic [7:0] uart_rx_byte,
    input  logic       cmd_vld,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_last,
    output logic [2:0] mode_o,
    output logic [1:0] host_if_o,
    output logic       irq_en_o
);

    localparam int              BOOT_W    = $clog2(BOOT_CYC + 1);
    localparam logic [BOOT_W-1:0] BOOT_LAST = BOOT_W'(BOOT_CYC - 1);

    state_e            state_q, state_d;
    logic [BOOT_W-1:0] boot_cnt_q;
    hif_e              hif_q, hif_smp;
    logic [1:0]        strap_q;
    logic              irq_q;
    logic              in_lb, in_host, wake, go_normal, go_vcard, vcard_irq;

    assign in_lb   = (state_q == ST_LB_OFF) || (state_q == ST_LB_CARD);
    assign in_host = (state_q == ST_AWAKE) || (state_q == ST_NORMAL) || (state_q == ST_VCARD);

    always_comb begin
        unique case ({if_strap0, if_strap1})
            2'b00: hif_smp = HIF_UART;
            2'b10: hif_smp = HIF_I2C;
            2'b01: hif_smp = HIF_SPI;
            2'b11: hif_smp = HIF_NONE;
        endcase
    end

    pwr_wake_detect #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm           (in_lb),
        .hif           (hif_q),
        .pad_pwr_ok    (pad_pwr_ok),
        .spi_cs_n      (spi_cs_n),
        .i2c_addr_vld  (i2c_addr_vld),
        .i2c_addr_byte (i2c_addr_byte),
        .uart_rx_vld   (uart_rx_vld),
        .uart_rx_byte  (uart_rx_byte),
        .wake_o        (wake)
    );

    pwr_cfg_decode u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (in_host),
        .cmd_vld   (cmd_vld),
        .cmd_byte  (cmd_byte),
        .cmd_last  (cmd_last),
        .go_normal (go_normal),
        .go_vcard  (go_vcard),
        .vcard_irq (vcard_irq)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: begin
                if (boot_cnt_q == BOOT_LAST) begin
                    if (strap_q == 2'b01)
                        state_d = ST_TEST_EMU;
                    else if (strap_q == 2'b00)
                        state_d = ST_TEST_RF;
                    else
                        state_d = field_on ? ST_LB_CARD : ST_LB_OFF;
                end
            end
            ST_LB_OFF, ST_LB_CARD: begin
                if (wake)
                    state_d = ST_AWAKE;
                else
                    state_d = field_on ? ST_LB_CARD : ST_LB_OFF;
            end
            ST_AWAKE, ST_NORMAL, ST_VCARD: begin
                if (go_normal)
                    state_d = ST_NORMAL;
                else if (go_vcard)
                    state_d = ST_VCARD;
            end
            ST_TEST_EMU, ST_TEST_RF: state_d = state_q;
        endcase
    end

    // State register and boot-time captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_BOOT;
            boot_cnt_q <= '0;
            hif_q      <= HIF_NONE;
            strap_q    <= 2'b11;
            irq_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BOOT) begin
                boot_cnt_q <= boot_cnt_q + 1'b1;
                if (boot_cnt_q == '0) begin
                    hif_q   <= hif_smp;
                    strap_q <= {mode_strap_hi, mode_strap_lo};
                end
            end
            if (in_host && go_normal)
                irq_q <= 1'b1;
            else if (in_host && go_vcard)
                irq_q <= vcard_irq;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_BOOT:     mode_o = MD_BOOT;
            ST_LB_OFF:   mode_o = MD_PDOWN;
            ST_LB_CARD:  mode_o = MD_LBCARD;
            ST_AWAKE:    mode_o = MD_AWAKE;
            ST_NORMAL:   mode_o = MD_NORMAL;
            ST_VCARD:    mode_o = MD_VCARD;
            ST_TEST_EMU: mode_o = MD_TEST_EMU;
            ST_TEST_RF:  mode_o = MD_TEST_RF;
        endcase
        host_if_o = hif_q;
        irq_en_o  = irq_q && in_host;
    end

    p_hif_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BOOT && $past(state_q) != ST_BOOT) |-> $stable(host_if_o));
    p_test_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_TEST_EMU || $past(state_q) == ST_TEST_RF) |-> (state_q == $past(state_q)));
    p_no_irq_lowbat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lb || state_q == ST_BOOT) |-> !irq_en_o);
    p_wake_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_lb) && state_q == ST_AWAKE) |-> $past(pad_pwr_ok));
    p_lowbat_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_lb) |-> (in_lb || state_q == ST_AWAKE));

endmodule

// File: tb/pwr_wake_ctrl_tb_top.sv
module pwr_wake_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 6;
    localparam int BC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       if_strap0 = 1'b0, if_strap1 = 1'b0;
    logic       mode_strap_hi = 1'b1, mode_strap_lo = 1'b1;
    logic       pad_pwr_ok = 1'b1, field_on = 1'b0, spi_cs_n = 1'b1;
    logic       i2c_addr_vld = 1'b0, uart_rx_vld = 1'b0, cmd_vld = 1'b0, cmd_last = 1'b0;
    logic [7:0] i2c_addr_byte = 8'h00, uart_rx_byte = 8'h00, cmd_byte = 8'h00;
    logic [2:0] mode_o;
    logic [1:0] host_if_o;
    logic       irq_en_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_wake_ctrl #(.WAKE_CYC(W), .BOOT_CYC(BC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .if_strap0(if_strap0), .if_strap1(if_strap1),
        .mode_strap_hi(mode_strap_hi), .mode_strap_lo(mode_strap_lo),
        .pad_pwr_ok(pad_pwr_ok), .field_on(field_on), .spi_cs_n(spi_cs_n),
        .i2c_addr_vld(i2c_addr_vld), .i2c_addr_byte(i2c_addr_byte),
        .uart_rx_vld(uart_rx_vld), .uart_rx_byte(uart_rx_byte),
        .cmd_vld(cmd_vld), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
        .mode_o(mode_o), .host_if_o(host_if_o), .irq_en_o(irq_en_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic chkm(input string tag, input int md, input int irq);
        chk({tag, " mode"}, int'(mode_o), md);
        chk({tag, " irq"}, int'(irq_en_o), irq);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit i0, input bit i1, input bit hi, input bit lo, input bit chk_boot);
        @(negedge clk);
        rst_n = 1'b0;
        if_strap0 = i0; if_strap1 = i1;
        mode_strap_hi = hi; mode_strap_lo = lo;
        pad_pwr_ok = 1'b1; field_on = 1'b0; spi_cs_n = 1'b1;
        i2c_addr_vld = 1'b0; uart_rx_vld = 1'b0; cmd_vld = 1'b0; cmd_last = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        if (chk_boot) begin
            cyc(BC - 1);
            chkm("R2 boot hold", 0, 0);
            cyc(1);
        end else begin
            cyc(BC);
        end
    endtask

    task automatic spi_hold(input int n);
        spi_cs_n = 1'b0;
        cyc(n);
        spi_cs_n = 1'b1;
    endtask

    task automatic i2c_addr(input logic [7:0] a);
        i2c_addr_vld = 1'b1; i2c_addr_byte = a;
        cyc(1);
        i2c_addr_vld = 1'b0;
    endtask

    task automatic uart_seq(input logic [95:0] bytes, input int n);
        for (int i = 0; i < n; i++) begin
            uart_rx_vld = 1'b1;
            uart_rx_byte = bytes[8*(n-1-i) +: 8];
            cyc(1);
        end
        uart_rx_vld = 1'b0;
    endtask

    task automatic cmd_frame(input logic [39:0] bytes, input int n);
        for (int i = 0; i < n; i++) begin
            cmd_vld = 1'b1;
            cmd_last = (i == n - 1);
            cmd_byte = bytes[8*(n-1-i) +: 8];
            cyc(1);
        end
        cmd_vld = 1'b0; cmd_last = 1'b0;
    endtask

    // Wake event kinds follow the host-link code: 0 UART, 1 I2C, 2 SPI.
    task automatic wake_event(input int k);
        if (k == 0) uart_seq(96'h5555_0000_0000_00FF, 8);
        else if (k == 1) begin i2c_addr(8'h48); cyc(W); end
        else spi_hold(W);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R1, R5, R6, R7, R8: sweep all host-link codes and all wake kinds
        for (int code = 0; code < 4; code++) begin
            bit i0 = code[0];
            bit i1 = code[1];
            int exp_if = (i0 && i1) ? 3 : (i0 ? 1 : (i1 ? 2 : 0));
            do_reset(i0, i1, 1'b1, 1'b1, code == 0);
            chk("R1 host code", int'(host_if_o), exp_if);
            chkm("R4 lowbat idle", 1, 0);
            for (int k = 0; k < 3; k++) begin
                if (k != exp_if) begin
                    wake_event(k);
                    cyc(2);
                    chkm("R8 foreign wake ignored", 1, 0);
                end
            end
            if (exp_if < 3) begin
                wake_event(exp_if);
                chkm("R5 R6 R7 selected wake", 3, 0);
            end
            chk("R1 host code held", int'(host_if_o), exp_if);
        end

        // R3: strap sweep
        for (int s = 0; s < 4; s++) begin
            bit hi = s[1];
            bit lo = s[0];
            int exp_md = hi ? 1 : (lo ? 6 : 7);
            do_reset(1'b0, 1'b1, hi, lo, 1'b0);
            chkm("R3 strap mode", exp_md, 0);
            if (!hi) begin
                spi_hold(W + 2);
                cmd_frame(40'h14_01, 2);
                chkm("R3 test mode sticky", exp_md, 0);
            end
        end

        // R4: field tracking in low battery (SPI strapped)
        do_reset(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        field_on = 1'b1; cyc(1);
        chkm("R4 field on", 2, 0);
        field_on = 1'b0; cyc(1);
        chkm("R4 field off", 1, 0);

        // R5: window boundary and pad power
        spi_hold(W - 1); cyc(2);
        chkm("R5 short hold", 1, 0);
        pad_pwr_ok = 1'b0; spi_hold(W + 3); pad_pwr_ok = 1'b1; cyc(1);
        chkm("R5 no pad power", 1, 0);
        // R10: command before wake is ignored
        cmd_frame(40'h14_01, 2);
        chkm("R10 cmd in lowbat", 1, 0);
        spi_cs_n = 1'b0; cyc(W - 1);
        chkm("R5 one short", 1, 0);
        cyc(1); spi_cs_n = 1'b1;
        chkm("R5 exact window", 3, 0);

        // R9, R10: sweep of the mode byte, high values first
        for (int b = 255; b >= 1; b--) begin
            cmd_frame({24'h0, 8'h14, 8'(b)}, 2);
            if (b == 1) chkm("R9 normal", 4, 1);
            else chkm("R10 unknown mode byte", 3, 0);
        end
        cmd_frame(40'h14_02_00, 3);     chkm("R9 vcard short", 5, 1);
        cmd_frame(40'h14_02_00_00, 4);  chkm("R9 vcard irq off", 5, 0);
        cmd_frame(40'h14_02_05, 3);     chkm("R10 bad fill", 5, 0);
        cmd_frame(40'h14_02_00_07, 4);  chkm("R10 bad irq byte", 5, 0);
        cmd_frame(40'h14_02_00_01, 4);  chkm("R9 vcard irq on", 5, 1);
        cmd_frame(40'h15_01, 2);        chkm("R10 bad opcode", 5, 1);
        cmd_frame(40'h14_02_00_01_05, 5); chkm("R10 too long", 5, 1);
        cmd_frame(40'h14_01, 2);        chkm("R9 back to normal", 4, 1);

        // R6: I2C address mismatch and pad power loss
        do_reset(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        i2c_addr(8'h49); cyc(W + 2);
        chkm("R6 wrong address", 1, 0);
        i2c_addr(8'h48); cyc(2);
        pad_pwr_ok = 1'b0; cyc(1); pad_pwr_ok = 1'b1; cyc(W + 2);
        chkm("R6 hold cancelled", 1, 0);
        i2c_addr(8'h48); cyc(W - 1);
        chkm("R6 hold running", 1, 0);
        cyc(1);
        chkm("R6 hold done", 3, 0);

        // R7: preamble search restart and near miss
        do_reset(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        uart_seq(96'h55_5500_0000_0000_FF, 7);
        chkm("R7 short preamble", 1, 0);
        uart_seq(96'h55_0055_5555_0000_0000_00, 10);
        chkm("R7 before end byte", 1, 0);
        uart_seq(96'hFF, 1);
        chkm("R7 overlap wake", 3, 0);

        // Same-edge case: wake completes while field rises and a frame ends
        do_reset(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        spi_cs_n = 1'b0; cyc(W - 2);
        cmd_vld = 1'b1; cmd_byte = 8'h14; cyc(1);
        field_on = 1'b1; cmd_last = 1'b1; cmd_byte = 8'h01; cyc(1);
        cmd_vld = 1'b0; cmd_last = 1'b0; spi_cs_n = 1'b1;
        chkm("R5 R10 wake beats field and frame", 3, 0);
        field_on = 1'b0;

        finished = 1;
        summary();
        $finish;
    end

endmodule